// File: doc/BRIEF.md
# Valley restart controller

This block sets the timing of the power switch in a quasi-resonant flyback converter. It holds one gate-drive enable. It decides when an ON pulse may begin and when it must end. Three digital inputs drive it:

- the demagnetization comparator, which is high while the auxiliary winding sits just below ground;
- the peak-current comparator;
- a skip-cycle hold request from the regulation loop.

A new ON pulse is accepted only when a ringing valley (a rising edge of the demagnetization signal) arrives after two windows have closed. The first is a short blanking window after turn-off, which hides the leakage ringing. The second is a minimum-period window, measured from the start of the previous pulse, which caps the switching frequency.

A timeout watchdog is cleared at turn-off and by every ringing edge. Once the drain ringing has died out, its expiry takes the place of the missing valley edge. This lets a cycle start as soon as the skip hold is released. Every duration is a parameter given in clock cycles. The default values correspond to 3 µs, 8 µs, 8 µs and 6 µs at 100 MHz.

Top module: `valley_restart`

## Requirements
- R1: While `rstN` is low, `gateOn` is 0. After reset the timeout counts as already expired, so the first ON pulse starts one clock after `skipHold` is low, with no demagnetization edge needed.
- R2: A valley event is a 0-to-1 transition of `demagIn` after a two-flop synchronizer. A qualifying edge driven on `demagIn` raises `gateOn` on the third rising clock edge after the input changes.
- R3: A steady high level on `demagIn`, and any edge that occurs while `gateOn` is 1, never starts an ON pulse.
- R4: For the first BLANK_CYC cycles after `gateOn` falls, demagnetization edges are ignored, even when the minimum period has already expired.
- R5: An ON pulse never starts less than MINPER_CYC cycles after the previous one started. An edge that arrives earlier is discarded, and expiry of the minimum period does not by itself start a pulse.
- R6: While `skipHold` is 1, no ON pulse starts, whatever the edges. After release, the next qualifying edge starts a pulse.
- R7: The timeout counter clears when `gateOn` falls and on every demagnetization edge. After TIMEOUT_CYC cycles with no edge, it acts as the restart event once the blanking, minimum-period and skip conditions allow.
- R8: A 1 on `peakIn` ends the ON pulse: `gateOn` falls on the third rising clock edge after `peakIn` rises.
- R9: An ON pulse lasts at most MAXON_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| demagIn | input | 1 | Demagnetization comparator, high while the winding is below ground (asynchronous) |
| peakIn | input | 1 | Peak-current comparator, high to end the ON time (asynchronous) |
| skipHold | input | 1 | Skip-cycle hold, high to block any restart (synchronous) |
| gateOn | output | 1 | Gate-drive enable |

## Verification
The assertions check on every cycle that each rise of `gateOn` followed a cycle in which three things held: the blanking window was closed, the minimum period had expired and the skip hold was low. They also check that a valley edge or an expired timeout was present in that cycle, that every fall has a peak or ON-limit cause, and that an edge leaves the timeout unexpired. Only the bench scenarios can show exact latencies and which edge wins the restart. These cover an edge swallowed by blanking, an early edge followed by a later one, a skip hold spanning several rings, and timeout-driven starts with no ringing at all.

// File: rtl/valley_restart_pkg.sv
package valley_restart_pkg;

  // Strobes from the control into the timing datapath.
  typedef struct packed {
    logic startOn;  // an ON pulse begins at this edge
    logic endOn;    // the ON pulse ends at this edge
  } ctrlStrobe_t;

endpackage

// File: rtl/valley_restart_satcnt.sv
// Saturating up-counter with synchronous clear. done is high in the
// LIMIT-th cycle counted from the clear.
module valley_restart_satcnt #(
  parameter int LIMIT      = 800,
  parameter bit RESET_DONE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic enable,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] INIT = RESET_DONE ? LAST : '0;

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     count <= INIT;
    else if (clear)                count <= '0;
    else if (enable && count != LAST) count <= count + 1'b1;
  end

  assign done = (count == LAST);
endmodule

// File: rtl/valley_restart_timing.sv
// Datapath: input synchronizers, valley edge detect and the four timers.
module valley_restart_timing
  import valley_restart_pkg::*;
#(
  parameter int BLANK_CYC   = 300,
  parameter int MINPER_CYC  = 800,
  parameter int TIMEOUT_CYC = 800,
  parameter int MAXON_CYC   = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        demagIn,
  input  logic        peakIn,
  input  logic        gateOn,
  input  ctrlStrobe_t strobe,
  output logic        demagEdge,
  output logic        peakSync,
  output logic        blankDone,
  output logic        minDone,
  output logic        toDone,
  output logic        onLimit
);
  logic [SYNC_STAGES-1:0] demagSh, peakSh;
  logic demagPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      demagSh   <= '0;
      peakSh    <= '0;
      demagPrev <= 1'b0;
    end else begin
      demagSh   <= {demagSh[SYNC_STAGES-2:0], demagIn};
      peakSh    <= {peakSh[SYNC_STAGES-2:0], peakIn};
      demagPrev <= demagSh[SYNC_STAGES-1];
    end
  end

  assign demagEdge = demagSh[SYNC_STAGES-1] & ~demagPrev;
  assign peakSync  = peakSh[SYNC_STAGES-1];

  // Leakage blanking, counted from turn-off.
  valley_restart_satcnt #(.LIMIT(BLANK_CYC), .RESET_DONE(1'b1)) blankTimer (
    .clk(clk), .rstN(rstN), .clear(strobe.endOn), .enable(1'b1), .done(blankDone));

  // Minimum switching period, counted from turn-on.
  valley_restart_satcnt #(.LIMIT(MINPER_CYC), .RESET_DONE(1'b1)) periodTimer (
    .clk(clk), .rstN(rstN), .clear(strobe.startOn), .enable(1'b1), .done(minDone));

  // No-ringing watchdog, re-armed at turn-off and by every ringing edge.
  valley_restart_satcnt #(.LIMIT(TIMEOUT_CYC), .RESET_DONE(1'b1)) ringTimer (
    .clk(clk), .rstN(rstN), .clear(strobe.endOn | demagEdge), .enable(1'b1), .done(toDone));

  // ON-time safety limit, counted only while the gate is driven.
  valley_restart_satcnt #(.LIMIT(MAXON_CYC), .RESET_DONE(1'b0)) onTimer (
    .clk(clk), .rstN(rstN), .clear(strobe.startOn), .enable(gateOn), .done(onLimit));

  // R7
  edge_rearms_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(demagEdge) |-> !toDone)
    else $error("timeout expired right after a ringing edge");
endmodule

// File: rtl/valley_restart_ctrl.sv
// Control: the restart latch that owns the gate enable.
module valley_restart_ctrl
  import valley_restart_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        skipHold,
  input  logic        demagEdge,
  input  logic        peakSync,
  input  logic        blankDone,
  input  logic        minDone,
  input  logic        toDone,
  input  logic        onLimit,
  output logic        gateOn,
  output ctrlStrobe_t strobe
);
  logic restartOk, stopOn;

  assign restartOk = !gateOn && !skipHold && blankDone && minDone && (demagEdge || toDone);
  assign stopOn    = gateOn && (peakSync || onLimit);

  always_comb begin
    strobe.startOn = restartOk;
    strobe.endOn   = stopOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          gateOn <= 1'b0;
    else if (restartOk) gateOn <= 1'b1;
    else if (stopOn)    gateOn <= 1'b0;
  end

  // R4
  rise_after_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(blankDone))
    else $error("restart inside blanking window");

  // R5
  rise_after_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(minDone))
    else $error("restart before minimum period");

  // R6
  rise_without_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> !$past(skipHold))
    else $error("restart during skip hold");

  // R2
  rise_has_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(demagEdge || toDone))
    else $error("restart without valley or timeout");

  // R8
  fall_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOn) |-> $past(peakSync || onLimit))
    else $error("gate dropped without cause");
endmodule

// File: rtl/valley_restart.sv
// Thin top: wires the timing datapath to the restart control.
module valley_restart
  import valley_restart_pkg::*;
#(
  parameter int BLANK_CYC   = 300,
  parameter int MINPER_CYC  = 800,
  parameter int TIMEOUT_CYC = 800,
  parameter int MAXON_CYC   = 600
) (
  input  logic clk,
  input  logic rstN,
  input  logic demagIn,
  input  logic peakIn,
  input  logic skipHold,
  output logic gateOn
);
  localparam int SYNC_STAGES = 2;

  ctrlStrobe_t strobe;
  logic demagEdge, peakSync, blankDone, minDone, toDone, onLimit;

  valley_restart_timing #(
    .BLANK_CYC(BLANK_CYC), .MINPER_CYC(MINPER_CYC), .TIMEOUT_CYC(TIMEOUT_CYC),
    .MAXON_CYC(MAXON_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) timing (
    .clk(clk), .rstN(rstN), .demagIn(demagIn), .peakIn(peakIn), .gateOn(gateOn),
    .strobe(strobe), .demagEdge(demagEdge), .peakSync(peakSync), .blankDone(blankDone),
    .minDone(minDone), .toDone(toDone), .onLimit(onLimit));

  valley_restart_ctrl ctrl (
    .clk(clk), .rstN(rstN), .skipHold(skipHold), .demagEdge(demagEdge),
    .peakSync(peakSync), .blankDone(blankDone), .minDone(minDone), .toDone(toDone),
    .onLimit(onLimit), .gateOn(gateOn), .strobe(strobe));
endmodule

// File: tb/valley_restart_test.sv
module valley_restart_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic demagIn = 1'b0;
  logic peakIn = 1'b0;
  logic skipHold = 1'b1;
  logic gateOn;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    logic  lvl;
    string req;
  } expEvt_t;
  expEvt_t expQ[$];

  valley_restart #(.BLANK_CYC(6), .MINPER_CYC(16), .TIMEOUT_CYC(30), .MAXON_CYC(12)) uut (
    .clk(clk), .rstN(rstN), .demagIn(demagIn), .peakIn(peakIn),
    .skipHold(skipHold), .gateOn(gateOn));

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic waitCyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic expectGate(input int at, input logic lvl, input string req);
    expEvt_t e;
    e.at = at; e.lvl = lvl; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic pulseDemag(input int c);
    waitCyc(c);     demagIn = 1'b1;
    waitCyc(c + 2); demagIn = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: every transition of gateOn is matched against the queue.
  logic lastGate = 1'b0;
  always @(negedge clk) begin
    if (rstN && gateOn !== lastGate) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected gate transition to %0b at cycle %0d (expected none)", gateOn, cyc);
      end else begin
        expEvt_t e;
        e = expQ.pop_front();
        if (e.at != cyc || e.lvl !== gateOn) begin
          failures++;
          $display("FAIL %s: gate=%0b at cycle %0d, expected gate=%0b at cycle %0d",
                   e.req, gateOn, cyc, e.lvl, e.at);
        end
      end
    end
    lastGate <= gateOn;
  end

  // Driver
  initial begin
    // Expected gate transitions
    expectGate(11,  1'b1, "R1 first start via expired timeout");
    expectGate(23,  1'b0, "R9 ON time limit");
    expectGate(43,  1'b1, "R4 blanked edge ignored, later edge R2");
    expectGate(55,  1'b0, "R9 ON time limit");
    expectGate(85,  1'b1, "R7 timeout restart, R3 steady level ignored");
    expectGate(91,  1'b0, "R8 peak ends ON");
    expectGate(103, 1'b1, "R5 early edge discarded, later edge used");
    expectGate(108, 1'b0, "R8 peak ends ON");
    expectGate(143, 1'b1, "R6 skip hold spans rings, next edge accepted");
    expectGate(148, 1'b0, "R8 peak ends ON");
    expectGate(191, 1'b1, "R7 timeout start on skip release");
    expectGate(196, 1'b0, "R8 peak ends ON");

    waitCyc(2);
    checks++;
    if (gateOn !== 1'b0) begin
      failures++;
      $display("FAIL R1: gate=%0b in reset, expected 0", gateOn);
    end
    waitCyc(3);  rstN = 1'b1;
    waitCyc(10); skipHold = 1'b0;
    // R4: edge at 26 lands inside blanking (period already expired)
    pulseDemag(24);
    pulseDemag(40);
    // R3: level held high across ON and OFF, no new edge
    waitCyc(45); demagIn = 1'b1;
    waitCyc(88); peakIn = 1'b1;
    waitCyc(90); demagIn = 1'b0;
    waitCyc(92); peakIn = 1'b0;
    // R5: early edge, then a valid one
    pulseDemag(95);
    pulseDemag(100);
    waitCyc(105); peakIn = 1'b1;
    waitCyc(108); skipHold = 1'b1;
    waitCyc(109); peakIn = 1'b0;
    // R6: rings during skip hold
    pulseDemag(120);
    pulseDemag(126);
    pulseDemag(132);
    waitCyc(136); skipHold = 1'b0;
    pulseDemag(140);
    waitCyc(145); peakIn = 1'b1;
    waitCyc(148); skipHold = 1'b1;
    waitCyc(149); peakIn = 1'b0;
    // R7: no ringing at all, hold then release
    waitCyc(190); skipHold = 1'b0;
    waitCyc(193); peakIn = 1'b1;
    waitCyc(196); skipHold = 1'b1;
    waitCyc(197); peakIn = 1'b0;
    waitCyc(240);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2: %0d expected gate transitions missing, expected 0", expQ.size());
    end
    report();
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run hung at cycle %0d, expected end by 240", cyc);
    report();
  end
endmodule